// File: doc/BRIEF.md
# Power State Sequencer

This block steps a chip through its power states: Off, Deep sleep, Light sleep, Wake-up and On. It runs on the always-on slow clock. From its state it drives the domain power enables, the crystal and PLL enables, a per-block clock-enable vector and a CPU clock gate. While the chip-enable input is low it holds every register in clear.

Bring-up always uses the same ordered sequence. The crystal turns on first, then a programmable settle count runs, then the PLL turns on. The block enters On only after the PLL reports lock. Software chooses which blocks receive the fast clock through a clock-control register. The CPU has its own gate, which closes on a wait-for-interrupt request and reopens on an interrupt. A sleep request leaves On for Deep sleep or Light sleep. A wake event from one of four sources brings the chip back, and the block acknowledges each source with a one-cycle pulse.

Top module: `pwr_seq_top`

## Requirements
- R1: The cycle after `chip_en` is sampled low, `pwr_state` is 0 (Off), `reg_clr` is 1 and all power, oscillator, clock and acknowledge outputs are 0. The clock-control register is also restored to `CLK_INIT`. Reset gives the same state. State codes: 0 Off, 1 Deep sleep, 2 Light sleep, 3 Wake-up, 4 On.
- R2: From Off with `chip_en` high, the block enters Wake-up (code 3) on the next cycle.
- R3: In Deep sleep only `rtc_pwr` is 1. `core_pwr`, `xtal_en`, `pll_en`, `blk_clk_en` and `cpu_clk_en` are all 0.
- R4: In Light sleep `rtc_pwr` and `core_pwr` are 1, and `xtal_en`, `pll_en`, every block clock and the CPU clock are 0.
- R5: A `sleep_req` sampled in On moves the block to Deep sleep when `sleep_deep` is 1, and to Light sleep when it is 0. A `sleep_req` sampled in any other state has no effect.
- R6: In Deep sleep or Light sleep, any nonzero `wake_src` moves the block to Wake-up on the next cycle. In that same cycle `wake_ack` shows the sampled bits for one cycle. Bit order: 0 MAC, 1 host, 2 RTC timer, 3 external interrupt.
- R7: In Wake-up, `xtal_en` is 1 with `pll_en` 0 for exactly `settle_cycles`+1 cycles, after which `pll_en` rises.
- R8: With `pll_en` on, the block stays in Wake-up until `pll_locked` is sampled high, and enters On on the following cycle.
- R9: Wake events sampled during Wake-up change nothing and are held. They appear on `wake_ack` in the cycle after the first On cycle. Wake events sampled in On are acknowledged on the next cycle.
- R10: In On, `blk_clk_en` equals the clock-control register, and a write takes effect on the next cycle. Outside On, `blk_clk_en` is 0.
- R11: In On, `cpu_wfi` closes the CPU clock on the next cycle and `cpu_irq` reopens it. `cpu_irq` wins when both are high. The gate always reopens when On is entered again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Always-on slow clock |
| rst | input | 1 | Synchronous active-high reset |
| chip_en | input | 1 | Chip enable; low forces Off |
| sleep_req | input | 1 | Sleep request strobe |
| sleep_deep | input | 1 | 1 selects Deep sleep, 0 Light sleep |
| wake_src | input | 4 | Wake events: MAC, host, RTC timer, external interrupt |
| settle_cycles | input | CNT_W | Crystal settle length minus one |
| pll_locked | input | 1 | PLL lock indication |
| ctrl_wr | input | 1 | Clock-control register write strobe |
| ctrl_data | input | NBLK | Clock-control register write data |
| cpu_wfi | input | 1 | CPU wait-for-interrupt request |
| cpu_irq | input | 1 | Interrupt that restores the CPU clock |
| pwr_state | output | 3 | Current power state code |
| rtc_pwr | output | 1 | RTC domain power enable |
| core_pwr | output | 1 | Main domain power enable |
| xtal_en | output | 1 | Crystal oscillator enable |
| pll_en | output | 1 | PLL enable |
| blk_clk_en | output | NBLK | Per-block fast clock enables |
| cpu_clk_en | output | 1 | CPU clock enable |
| reg_clr | output | 1 | Global register clear |
| wake_ack | output | 4 | One-cycle wake acknowledge per source |

## Verification
The bench targets settle counts of zero and of several cycles. A design with an off-by-one counter would raise the PLL one cycle early or late. It also holds the PLL unlocked for several cycles and sends a wake event during the wake sequence. A design that acted on that event, or lost it, would restart or never acknowledge it. The bench drops chip enable in On and in Deep sleep to expose a clock register that survives a power-off, or a gate that stays closed. It raises sleep requests outside On and asserts wait-for-interrupt together with an interrupt, where a design with the wrong priority would freeze the CPU clock.

// File: rtl/pwr_seq_pkg.sv
package pwr_seq_pkg;

    localparam int WAKE_N = 4;

    typedef enum logic [2:0] {
        PH_OFF   = 3'd0,
        PH_DEEP  = 3'd1,
        PH_SLEEP = 3'd2,
        PH_XTAL  = 3'd3,
        PH_ON    = 3'd4,
        PH_PLL   = 3'd5
    } phase_e;

    typedef struct packed {
        logic rtc;
        logic core;
        logic xtal;
        logic pll;
    } dom_en_t;

    // Externally visible state code: both wake phases report Wake-up.
    function automatic logic [2:0] state_code(phase_e p);
        return (p == PH_PLL) ? 3'd3 : 3'(p);
    endfunction

    function automatic dom_en_t dom_for(phase_e p);
        dom_en_t d;
        d = '0;
        case (p)
            PH_DEEP:  d.rtc = 1'b1;
            PH_SLEEP: begin d.rtc = 1'b1; d.core = 1'b1; end
            PH_XTAL:  begin d.rtc = 1'b1; d.core = 1'b1; d.xtal = 1'b1; end
            PH_PLL, PH_ON: begin
                d.rtc = 1'b1; d.core = 1'b1; d.xtal = 1'b1; d.pll = 1'b1;
            end
            default: d = '0;
        endcase
        return d;
    endfunction

endpackage

// File: rtl/pwr_fsm.sv
module pwr_fsm
    import pwr_seq_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              sleep_req,
    input  logic              sleep_deep,
    input  logic [WAKE_N-1:0] wake_src,
    input  logic [CNT_W-1:0]  settle_cycles,
    input  logic              pll_locked,
    output phase_e            phase,
    output logic [WAKE_N-1:0] wake_ack
);

    phase_e             ph_q;
    logic [CNT_W-1:0]   cnt_q;
    logic [WAKE_N-1:0]  pend_q;
    logic [WAKE_N-1:0]  ack_q;

    always_ff @(posedge clk) begin
        if (rst || !chip_en) begin
            ph_q   <= PH_OFF;
            cnt_q  <= '0;
            pend_q <= '0;
            ack_q  <= '0;
        end else begin
            ack_q <= '0;
            case (ph_q)
                PH_OFF: begin
                    ph_q  <= PH_XTAL;
                    cnt_q <= '0;
                end
                PH_DEEP, PH_SLEEP: begin
                    ack_q <= wake_src;
                    if (|wake_src) begin
                        ph_q  <= PH_XTAL;
                        cnt_q <= '0;
                    end
                end
                PH_XTAL: begin
                    pend_q <= pend_q | wake_src;
                    if (cnt_q >= settle_cycles) begin
                        ph_q  <= PH_PLL;
                        cnt_q <= '0;
                    end else begin
                        cnt_q <= cnt_q + CNT_W'(1);
                    end
                end
                PH_PLL: begin
                    pend_q <= pend_q | wake_src;
                    if (pll_locked) ph_q <= PH_ON;
                end
                PH_ON: begin
                    ack_q  <= pend_q | wake_src;
                    pend_q <= '0;
                    if (sleep_req) ph_q <= sleep_deep ? PH_DEEP : PH_SLEEP;
                end
                default: ph_q <= PH_OFF;
            endcase
        end
    end

    assign phase    = ph_q;
    assign wake_ack = ack_q;

endmodule

// File: rtl/clk_gate_ctl.sv
module clk_gate_ctl
    import pwr_seq_pkg::*;
#(
    parameter int              NBLK     = 8,
    parameter logic [NBLK-1:0] CLK_INIT = '1
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            chip_en,
    input  phase_e          phase,
    input  logic            ctrl_wr,
    input  logic [NBLK-1:0] ctrl_data,
    input  logic            cpu_wfi,
    input  logic            cpu_irq,
    output logic [NBLK-1:0] blk_clk_en,
    output logic            cpu_clk_en
);

    logic [NBLK-1:0] ctrl_q;
    logic            gated_q;
    logic            on;

    assign on = (phase == PH_ON);

    always_ff @(posedge clk) begin
        if (rst || !chip_en || phase == PH_OFF) begin
            ctrl_q <= CLK_INIT;
        end else if (ctrl_wr) begin
            ctrl_q <= ctrl_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !on) begin
            gated_q <= 1'b0;
        end else if (cpu_irq) begin
            gated_q <= 1'b0;
        end else if (cpu_wfi) begin
            gated_q <= 1'b1;
        end
    end

    for (genvar i = 0; i < NBLK; i++) begin : g_blk
        assign blk_clk_en[i] = on & ctrl_q[i];
    end

    assign cpu_clk_en = on & ~gated_q;

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pwr_seq_pkg::*;
#(
    parameter int              NBLK     = 8,
    parameter int              CNT_W    = 16,
    parameter logic [NBLK-1:0] CLK_INIT = '1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              chip_en,
    input  logic              sleep_req,
    input  logic              sleep_deep,
    input  logic [3:0]        wake_src,
    input  logic [CNT_W-1:0]  settle_cycles,
    input  logic              pll_locked,
    input  logic              ctrl_wr,
    input  logic [NBLK-1:0]   ctrl_data,
    input  logic              cpu_wfi,
    input  logic              cpu_irq,
    output logic [2:0]        pwr_state,
    output logic              rtc_pwr,
    output logic              core_pwr,
    output logic              xtal_en,
    output logic              pll_en,
    output logic [NBLK-1:0]   blk_clk_en,
    output logic              cpu_clk_en,
    output logic              reg_clr,
    output logic [3:0]        wake_ack
);

    phase_e  phase;
    dom_en_t dom;

    pwr_fsm #(.CNT_W(CNT_W)) u_fsm (
        .clk           (clk),
        .rst           (rst),
        .chip_en       (chip_en),
        .sleep_req     (sleep_req),
        .sleep_deep    (sleep_deep),
        .wake_src      (wake_src),
        .settle_cycles (settle_cycles),
        .pll_locked    (pll_locked),
        .phase         (phase),
        .wake_ack      (wake_ack)
    );

    clk_gate_ctl #(.NBLK(NBLK), .CLK_INIT(CLK_INIT)) u_clk (
        .clk        (clk),
        .rst        (rst),
        .chip_en    (chip_en),
        .phase      (phase),
        .ctrl_wr    (ctrl_wr),
        .ctrl_data  (ctrl_data),
        .cpu_wfi    (cpu_wfi),
        .cpu_irq    (cpu_irq),
        .blk_clk_en (blk_clk_en),
        .cpu_clk_en (cpu_clk_en)
    );

    assign dom       = dom_for(phase);
    assign rtc_pwr   = dom.rtc;
    assign core_pwr  = dom.core;
    assign xtal_en   = dom.xtal;
    assign pll_en    = dom.pll;
    assign pwr_state = state_code(phase);
    assign reg_clr   = (phase == PH_OFF);

endmodule

// File: rtl/pwr_seq_chk.sv
module pwr_seq_chk #(
    parameter int NBLK = 8
) (
    input logic            clk,
    input logic            rst,
    input logic            chip_en,
    input logic            sleep_req,
    input logic            sleep_deep,
    input logic [3:0]      wake_src,
    input logic            pll_locked,
    input logic            cpu_wfi,
    input logic            cpu_irq,
    input logic [2:0]      pwr_state,
    input logic            rtc_pwr,
    input logic            core_pwr,
    input logic            xtal_en,
    input logic            pll_en,
    input logic [NBLK-1:0] blk_clk_en,
    input logic            cpu_clk_en,
    input logic            reg_clr,
    input logic [3:0]      wake_ack
);

    p_off_clear_r1: assert property (@(posedge clk) disable iff (rst)
        !chip_en |=> (pwr_state == 3'd0 && reg_clr && !rtc_pwr && !core_pwr &&
                      !xtal_en && !pll_en && blk_clk_en == '0 && !cpu_clk_en &&
                      wake_ack == 4'd0));

    p_deep_dom_r3: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 3'd1 |-> (rtc_pwr && !core_pwr && !xtal_en && !pll_en &&
                               blk_clk_en == '0 && !cpu_clk_en));

    p_light_dom_r4: assert property (@(posedge clk) disable iff (rst)
        pwr_state == 3'd2 |-> (rtc_pwr && core_pwr && !xtal_en && !pll_en &&
                               blk_clk_en == '0 && !cpu_clk_en));

    p_sleep_go_r5: assert property (@(posedge clk) disable iff (rst)
        (chip_en && pwr_state == 3'd4 && sleep_req) |=>
            (pwr_state == ($past(sleep_deep) ? 3'd1 : 3'd2)));

    p_wake_go_r6: assert property (@(posedge clk) disable iff (rst)
        (chip_en && (pwr_state == 3'd1 || pwr_state == 3'd2) && wake_src != 4'd0) |=>
            (pwr_state == 3'd3 && wake_ack == $past(wake_src)));

    p_lock_first_r8: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd4 && $past(pwr_state) == 3'd3) |->
            ($past(pll_locked) && $past(pll_en)));

    p_clk_only_on_r10: assert property (@(posedge clk) disable iff (rst)
        pwr_state != 3'd4 |-> (blk_clk_en == '0 && !cpu_clk_en));

    p_wfi_gate_r11: assert property (@(posedge clk) disable iff (rst)
        (pwr_state == 3'd4 && cpu_wfi && !cpu_irq) |=> !cpu_clk_en);

    p_irq_open_r11: assert property (@(posedge clk) disable iff (rst)
        (chip_en && pwr_state == 3'd4 && cpu_irq && !sleep_req) |=> cpu_clk_en);

endmodule

bind pwr_seq_top pwr_seq_chk #(.NBLK(NBLK)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .chip_en    (chip_en),
    .sleep_req  (sleep_req),
    .sleep_deep (sleep_deep),
    .wake_src   (wake_src),
    .pll_locked (pll_locked),
    .cpu_wfi    (cpu_wfi),
    .cpu_irq    (cpu_irq),
    .pwr_state  (pwr_state),
    .rtc_pwr    (rtc_pwr),
    .core_pwr   (core_pwr),
    .xtal_en    (xtal_en),
    .pll_en     (pll_en),
    .blk_clk_en (blk_clk_en),
    .cpu_clk_en (cpu_clk_en),
    .reg_clr    (reg_clr),
    .wake_ack   (wake_ack)
);

// File: tb/tb_pwr_seq_top.sv
`timescale 1ns/1ps
module tb_pwr_seq_top;

    localparam int NBLK  = 8;
    localparam int CNT_W = 16;
    localparam int INIT  = (1 << NBLK) - 1;

    logic clk = 1'b0;
    always #4 clk = ~clk;

    logic             rst, chip_en, sleep_req, sleep_deep, pll_locked;
    logic [3:0]       wake_src;
    logic [CNT_W-1:0] settle_cycles;
    logic             ctrl_wr, cpu_wfi, cpu_irq;
    logic [NBLK-1:0]  ctrl_data;
    logic [2:0]       pwr_state;
    logic             rtc_pwr, core_pwr, xtal_en, pll_en, cpu_clk_en, reg_clr;
    logic [NBLK-1:0]  blk_clk_en;
    logic [3:0]       wake_ack;

    pwr_seq_top #(.NBLK(NBLK), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst(rst), .chip_en(chip_en), .sleep_req(sleep_req),
        .sleep_deep(sleep_deep), .wake_src(wake_src), .settle_cycles(settle_cycles),
        .pll_locked(pll_locked), .ctrl_wr(ctrl_wr), .ctrl_data(ctrl_data),
        .cpu_wfi(cpu_wfi), .cpu_irq(cpu_irq), .pwr_state(pwr_state),
        .rtc_pwr(rtc_pwr), .core_pwr(core_pwr), .xtal_en(xtal_en), .pll_en(pll_en),
        .blk_clk_en(blk_clk_en), .cpu_clk_en(cpu_clk_en), .reg_clr(reg_clr),
        .wake_ack(wake_ack)
    );

    int errs = 0;
    int checks = 0;
    bit done = 0;

    // Reference model: 0 off, 1 deep, 2 light, 3 crystal wait, 6 pll wait, 4 on
    int m_ph = 0, m_cnt = 0, m_pend = 0, m_gated = 0, m_creg = INIT, m_ack = 0;

    always @(posedge clk) begin
        int cur;
        cur = m_ph;
        if (rst || !chip_en) begin
            m_ph = 0; m_cnt = 0; m_pend = 0; m_gated = 0; m_creg = INIT; m_ack = 0;
        end else begin
            if (cur == 4) begin
                if (cpu_irq) m_gated = 0;
                else if (cpu_wfi) m_gated = 1;
            end else begin
                m_gated = 0;
            end
            if (cur != 0 && ctrl_wr) m_creg = int'(ctrl_data);
            m_ack = 0;
            if (cur == 0) begin
                m_ph = 3; m_cnt = 0;
            end else if (cur == 1 || cur == 2) begin
                m_ack = int'(wake_src);
                if (wake_src != 0) begin m_ph = 3; m_cnt = 0; end
            end else if (cur == 3) begin
                m_pend = m_pend | int'(wake_src);
                if (m_cnt >= int'(settle_cycles)) begin m_ph = 6; m_cnt = 0; end
                else m_cnt = m_cnt + 1;
            end else if (cur == 6) begin
                m_pend = m_pend | int'(wake_src);
                if (pll_locked) m_ph = 4;
            end else begin
                m_ack = m_pend | int'(wake_src);
                m_pend = 0;
                if (sleep_req) m_ph = sleep_deep ? 1 : 2;
            end
        end
    end

    task automatic chk(string req, string what, int got, int exp);
        checks++;
        if (got != exp) begin
            errs++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", req, what, got, exp, $time);
        end
    endtask

    task automatic compare_all();
        int code;
        code = (m_ph == 6) ? 3 : m_ph;
        chk("R5", "pwr_state", int'(pwr_state), code);
        chk("R1", "reg_clr", int'(reg_clr), (m_ph == 0) ? 1 : 0);
        chk("R3", "rtc_pwr", int'(rtc_pwr), (m_ph != 0) ? 1 : 0);
        chk("R4", "core_pwr", int'(core_pwr), (m_ph >= 2) ? 1 : 0);
        chk("R7", "xtal_en", int'(xtal_en), (m_ph >= 3) ? 1 : 0);
        chk("R8", "pll_en", int'(pll_en), (m_ph == 4 || m_ph == 6) ? 1 : 0);
        chk("R10", "blk_clk_en", int'(blk_clk_en), (m_ph == 4) ? m_creg : 0);
        chk("R11", "cpu_clk_en", int'(cpu_clk_en), (m_ph == 4 && m_gated == 0) ? 1 : 0);
        chk("R6", "wake_ack", int'(wake_ack), m_ack);
    endtask

    task automatic tick();
        @(negedge clk);
        compare_all();
    endtask

    task automatic count_settle(string req, int exp);
        int n = 0;
        while (xtal_en && !pll_en && n < 100) begin
            n++;
            tick();
        end
        chk(req, "crystal-only cycles", n, exp);
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errs++;
            checks++;
            $display("FAIL watchdog expired");
            $display("Result: errors=%0d of %0d checks", errs, checks);
            $finish;
        end
    end

    initial begin
        rst = 1; chip_en = 0; sleep_req = 0; sleep_deep = 0; pll_locked = 0;
        wake_src = 0; settle_cycles = 3; ctrl_wr = 0; ctrl_data = 0;
        cpu_wfi = 0; cpu_irq = 0;
        repeat (3) tick();
        chk("R1", "reset reg_clr", int'(reg_clr), 1);
        chk("R1", "reset state", int'(pwr_state), 0);
        rst = 0;
        tick();

        // R2 cold start, R7 settle length 3 -> 4 crystal-only cycles
        chip_en = 1;
        tick();
        chk("R2", "state after enable", int'(pwr_state), 3);
        count_settle("R7", 4);

        // R8 unlocked PLL holds wake-up; R9 wake latched meanwhile
        wake_src = 4'b0001;
        tick();
        wake_src = 0;
        tick(); tick();
        chk("R8", "still waking", int'(pwr_state), 3);
        chk("R9", "no ack while waking", int'(wake_ack), 0);
        pll_locked = 1;
        tick();
        chk("R8", "on after lock", int'(pwr_state), 4);
        chk("R9", "ack not yet", int'(wake_ack), 0);
        tick();
        chk("R9", "held MAC ack", int'(wake_ack), 1);

        // R10 clock-control register
        chk("R10", "init blocks", int'(blk_clk_en), INIT);
        ctrl_wr = 1; ctrl_data = 8'hA5;
        tick();
        ctrl_wr = 0;
        chk("R10", "written blocks", int'(blk_clk_en), 8'hA5);

        // R11 CPU gate
        cpu_wfi = 1;
        tick();
        cpu_wfi = 0;
        chk("R11", "wfi closes", int'(cpu_clk_en), 0);
        tick();
        cpu_wfi = 1; cpu_irq = 1;
        tick();
        cpu_wfi = 0; cpu_irq = 0;
        chk("R11", "irq wins", int'(cpu_clk_en), 1);
        cpu_wfi = 1;
        tick();
        cpu_wfi = 0;

        // R5 light sleep, R4 domains
        sleep_req = 1; sleep_deep = 0;
        tick();
        sleep_req = 0;
        chk("R5", "light sleep entered", int'(pwr_state), 2);
        chk("R4", "core kept", int'(core_pwr), 1);
        tick(); tick();

        // R6 host wake, R5 sleep request during wake-up ignored
        settle_cycles = 0;
        wake_src = 4'b0010;
        tick();
        wake_src = 0;
        chk("R6", "wake state", int'(pwr_state), 3);
        chk("R6", "host ack", int'(wake_ack), 2);
        sleep_req = 1;
        tick();
        sleep_req = 0;
        chk("R5", "request ignored in wake", int'(pwr_state), 3);
        tick(); tick();
        chk("R11", "gate reopened", int'(cpu_clk_en), 1);
        chk("R10", "register kept", int'(blk_clk_en), 8'hA5);

        // R3 deep sleep, request there ignored
        sleep_req = 1; sleep_deep = 1;
        tick();
        sleep_req = 0; sleep_deep = 0;
        chk("R3", "deep entered", int'(pwr_state), 1);
        chk("R3", "core off", int'(core_pwr), 0);
        sleep_req = 1;
        tick();
        sleep_req = 0;
        chk("R5", "request ignored in deep", int'(pwr_state), 1);

        // R6 external wake, R7 settle 0 -> 1 crystal-only cycle
        wake_src = 4'b1000;
        tick();
        wake_src = 0;
        chk("R6", "ext ack", int'(wake_ack), 8);
        count_settle("R7", 1);
        tick();
        chk("R8", "on again", int'(pwr_state), 4);

        // R1 power off from on, register restored
        chip_en = 0;
        tick();
        chk("R1", "off state", int'(pwr_state), 0);
        chk("R1", "clear high", int'(reg_clr), 1);
        settle_cycles = 2;
        wake_src = 4'b0100;
        chip_en = 1;
        tick();
        wake_src = 0;
        for (int i = 0; i < 20 && pwr_state != 3'd4; i++) tick();
        chk("R1", "register restored", int'(blk_clk_en), INIT);
        tick();

        // R1 power off from deep sleep
        sleep_req = 1; sleep_deep = 1;
        tick();
        sleep_req = 0;
        chip_en = 0;
        tick();
        chk("R1", "off from deep", int'(pwr_state), 0);
        chk("R1", "rtc off", int'(rtc_pwr), 0);
        tick(); tick();

        done = 1;
        $display("Result: errors=%0d of %0d checks", errs, checks);
        $finish;
    end

endmodule